// File: doc/BRIEF.md
# Hot-swap power-up sequencer

This block decides when a hot-plugged card may close its pass transistor and when it may report power-good. It watches two active-low seat-detect contacts, a master enable and a supply-in-window flag. When all four have stayed valid for a selectable qualification interval, it raises the gate enable. Once the gate has been seen near the rail (that observation is remembered) and the drain is low, it waits a selectable delay and then drives the active-low power-good.

After power-good first asserts, a holdoff window of the same length as the power-good delay begins. Inside that window a low level on the active-low forced-shutdown input has no effect. After the window, a low level on that input latches a fault, which turns off both the gate and power-good. A configuration input can instead make the forced-shutdown input act as a second power-good enable. A fault from the protection logic also forces the fault state. The fault is held until the master enable goes low.

All external flags pass through two-flop synchronizers, and all outputs are registered. A change on an input therefore reaches the outputs on the third rising clock edge after the change. Delays are counted in units of 50 µs, and the parameter `CLK_PER_UNIT` gives the number of clock cycles in one unit.

Top module: `hs_seq_ctrl`

## Requirements
- R1: While reset is applied, and afterwards until qualification completes, gate_en is 0, pg_n is 1 and fault_req is 0.
- R2: With seat_a_n=0, seat_b_n=0, master_en=1 and supply_ok=1 all applied together and held, gate_en is still 0 after rising edge Q+2 and is 1 after rising edge Q+3, counting from the change. Q = (qualification units) × CLK_PER_UNIT.
- R3: The qual_sel encoding gives qualification units as follows: 00 gives 1600 units (80 ms, the default), 01 gives 10 units (0.5 ms), 10 gives 100 units (5 ms) and 11 gives 3200 units (160 ms).
- R4: If any of the four enables becomes invalid during qualification, the block returns to idle and clears its count. Qualification then restarts in full once the enables are valid again.
- R5: pg_n goes low only while gate_en is 1, and only after gate_high has been seen at least once with drain_low=1. A one-cycle pulse on gate_high is enough. pg_n is still 1 after edge P+2 and 0 after edge P+3, counting from the cycle in which both conditions are first applied. P = (delay units) × CLK_PER_UNIT.
- R6: The pgd_sel encoding gives delay units as follows: 000 gives 100 units (5 ms, the default), 001 gives 1, 010 gives 5, 011 gives 10, 100 gives 30, 101 gives 400, 110 gives 1600 and 111 gives 3200.
- R7: While power-good conditions hold, pg_en=0 releases pg_n (pg_n=1) and pg_en=1 drives it (pg_n=0), each on the third edge after the change.
- R8: With fshut_is_pg_en=0, fshut_n is ignored for P cycles after pg_n first goes low. If fshut_n is low after that, fault_req becomes 1 and gate_en and pg_n become 0 and 1, one edge after the holdoff ends.
- R9: With fshut_is_pg_en=1, fshut_n=0 releases pg_n and fshut_n=1 drives it, each on the third edge after the change, and no fault is raised.
- R10: Losing any of the four enables while the gate is on drives gate_en to 0 and pg_n to 1 on the third edge, without a fault.
- R11: prot_fault=1 while the gate is on gives fault_req=1, gate_en=0 and pg_n=1 on the third edge.
- R12: A fault is held while master_en stays 1, even if its cause goes away. master_en=0 clears fault_req on the third edge and returns the block to idle.
- R13: While power-good is on, drain_low=0 releases pg_n on the third edge without a fault, and drain_low=1 drives it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| seat_a_n | input | 1 | First seat-detect contact, low when seated |
| seat_b_n | input | 1 | Second seat-detect contact, low when seated |
| master_en | input | 1 | Master enable, high to allow power-up |
| supply_ok | input | 1 | Host supply within under/over-voltage window |
| gate_high | input | 1 | Gate voltage has neared the supply rail |
| drain_low | input | 1 | Transistor drain below its on threshold |
| pg_en | input | 1 | Power-good enable |
| fshut_n | input | 1 | Active-low forced shutdown from the secondary side |
| prot_fault | input | 1 | Trip request from the protection logic |
| qual_sel | input | 2 | Qualification interval code (R3) |
| pgd_sel | input | 3 | Power-good delay and holdoff code (R6) |
| fshut_is_pg_en | input | 1 | 1: fshut_n acts as a second power-good enable |
| gate_en | output | 1 | Enable for the gate drive of the pass transistor |
| pg_n | output | 1 | Active-low power-good |
| fault_req | output | 1 | Latched fault indication |

## Verification
The bench builds the block with CLK_PER_UNIT=2, so each 50 µs unit lasts two clock cycles. With that value the short codes give intervals of 20, 10 and 2 cycles, so the exact edge at which qualification, the power-good delay and the holdoff end can be checked on both sides of the boundary. At the same value, the default codes (3200 and 200 cycles) are still short enough to run once and confirm that the all-zero codes select the defaults.

// File: rtl/hs_seq_pkg.sv
package hs_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_QUAL,
        ST_RAMP,
        ST_PGWAIT,
        ST_ON,
        ST_FAULT
    } seq_st_e;

    localparam int UNIT_W    = 12;
    localparam int MAX_UNITS = 3200;

    // qualification interval in 50 us units; all-zero code is the default
    function automatic logic [UNIT_W-1:0] qual_units(input logic [1:0] code);
        case (code)
            2'b01:   return UNIT_W'(10);
            2'b10:   return UNIT_W'(100);
            2'b11:   return UNIT_W'(3200);
            default: return UNIT_W'(1600);
        endcase
    endfunction

    // power-good delay (and holdoff) in 50 us units; all-zero code is the default
    function automatic logic [UNIT_W-1:0] pgd_units(input logic [2:0] code);
        case (code)
            3'b001:  return UNIT_W'(1);
            3'b010:  return UNIT_W'(5);
            3'b011:  return UNIT_W'(10);
            3'b100:  return UNIT_W'(30);
            3'b101:  return UNIT_W'(400);
            3'b110:  return UNIT_W'(1600);
            3'b111:  return UNIT_W'(3200);
            default: return UNIT_W'(100);
        endcase
    endfunction

endpackage

// File: rtl/hs_sync2.sv
module hs_sync2 #(
    parameter int          WIDTH   = 1,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
        end
    end

    assign dout = sync_q;
endmodule

// File: rtl/hs_delay_sel.sv
module hs_delay_sel
    import hs_seq_pkg::*;
#(
    parameter int CLK_PER_UNIT = 5000,
    parameter int CNT_W        = 24
) (
    input  logic [1:0]       qual_sel,
    input  logic [2:0]       pgd_sel,
    output logic [CNT_W-1:0] qual_last,
    output logic [CNT_W-1:0] pgd_last
);
    localparam logic [CNT_W-1:0] CPU = CNT_W'(CLK_PER_UNIT);

    // terminal count = ticks - 1, since the counter starts at zero
    always_comb begin
        qual_last = CNT_W'(qual_units(qual_sel)) * CPU - CNT_W'(1);
        pgd_last  = CNT_W'(pgd_units(pgd_sel)) * CPU - CNT_W'(1);
    end
endmodule

// File: rtl/hs_seq_ctrl.sv
module hs_seq_ctrl
    import hs_seq_pkg::*;
#(
    parameter int CLK_PER_UNIT = 5000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       seat_a_n,
    input  logic       seat_b_n,
    input  logic       master_en,
    input  logic       supply_ok,
    input  logic       gate_high,
    input  logic       drain_low,
    input  logic       pg_en,
    input  logic       fshut_n,
    input  logic       prot_fault,
    input  logic [1:0] qual_sel,
    input  logic [2:0] pgd_sel,
    input  logic       fshut_is_pg_en,
    output logic       gate_en,
    output logic       pg_n,
    output logic       fault_req
);
    localparam int CNT_W  = $clog2(MAX_UNITS * CLK_PER_UNIT + 1);
    localparam int N_SYNC = 9;
    // order: seat_a_n, seat_b_n, master_en, supply_ok, gate_high,
    //        drain_low, pg_en, fshut_n, prot_fault
    localparam logic [N_SYNC-1:0] SYNC_RST = 9'b110000010;

    typedef struct packed {
        seq_st_e          st;
        logic [CNT_W-1:0] cnt;     // qualify / pg delay / holdoff, by state
        logic             gh_seen;
        logic             ho_run;
        logic             ho_done;
        logic             gate;
        logic             pg_n;
        logic             fault;
    } ctl_t;

    logic [N_SYNC-1:0] raw_in, syn;
    logic sa_n_s, sb_n_s, men_s, sup_s, gh_s, dl_s, pgen_s, fsn_s, pf_s;
    logic all_ok_s;
    logic [CNT_W-1:0] qual_last, pgd_last;
    ctl_t ctl_d, ctl_q;

    assign raw_in = {seat_a_n, seat_b_n, master_en, supply_ok, gate_high,
                     drain_low, pg_en, fshut_n, prot_fault};

    hs_sync2 #(.WIDTH(N_SYNC), .RST_VAL(SYNC_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw_in),
        .dout  (syn)
    );

    assign {sa_n_s, sb_n_s, men_s, sup_s, gh_s, dl_s, pgen_s, fsn_s, pf_s} = syn;
    assign all_ok_s = ~sa_n_s & ~sb_n_s & men_s & sup_s;

    hs_delay_sel #(.CLK_PER_UNIT(CLK_PER_UNIT), .CNT_W(CNT_W)) u_dly (
        .qual_sel  (qual_sel),
        .pgd_sel   (pgd_sel),
        .qual_last (qual_last),
        .pgd_last  (pgd_last)
    );

    function automatic logic gate_state(input seq_st_e s);
        return (s == ST_RAMP) || (s == ST_PGWAIT) || (s == ST_ON);
    endfunction

    always_comb begin
        logic pg_on;
        ctl_d = ctl_q;
        unique case (ctl_q.st)
            ST_IDLE: begin
                ctl_d.cnt     = '0;
                ctl_d.gh_seen = 1'b0;
                ctl_d.ho_run  = 1'b0;
                ctl_d.ho_done = 1'b0;
                if (all_ok_s) ctl_d.st = ST_QUAL;
            end
            ST_QUAL: begin
                if (!all_ok_s) begin
                    ctl_d.st  = ST_IDLE;
                    ctl_d.cnt = '0;
                end else if (ctl_q.cnt == qual_last) begin
                    ctl_d.st  = ST_RAMP;
                    ctl_d.cnt = '0;
                end else begin
                    ctl_d.cnt = ctl_q.cnt + CNT_W'(1);
                end
            end
            ST_RAMP: begin
                if (gh_s) ctl_d.gh_seen = 1'b1;
                if ((ctl_q.gh_seen || gh_s) && dl_s) begin
                    ctl_d.st  = ST_PGWAIT;
                    ctl_d.cnt = '0;
                end
            end
            ST_PGWAIT: begin
                if (!dl_s) begin
                    ctl_d.st  = ST_RAMP;
                    ctl_d.cnt = '0;
                end else if (ctl_q.cnt == pgd_last) begin
                    ctl_d.st  = ST_ON;
                    ctl_d.cnt = '0;
                end else begin
                    ctl_d.cnt = ctl_q.cnt + CNT_W'(1);
                end
            end
            ST_ON: begin
                // holdoff window reuses the delay counter
                if (ctl_q.ho_run && !ctl_q.ho_done) begin
                    if (ctl_q.cnt == pgd_last) ctl_d.ho_done = 1'b1;
                    else                       ctl_d.cnt = ctl_q.cnt + CNT_W'(1);
                end
                if (ctl_q.ho_done && !fshut_is_pg_en && !fsn_s)
                    ctl_d.st = ST_FAULT;
            end
            ST_FAULT: begin
                if (!men_s) ctl_d.st = ST_IDLE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase

        if (gate_state(ctl_q.st)) begin
            if (pf_s)           ctl_d.st = ST_FAULT;
            else if (!all_ok_s) ctl_d.st = ST_IDLE;
        end

        pg_on = (ctl_d.st == ST_ON) && pgen_s && dl_s &&
                (!fshut_is_pg_en || fsn_s);
        if (pg_on) ctl_d.ho_run = 1'b1;

        ctl_d.gate  = gate_state(ctl_d.st);
        ctl_d.pg_n  = ~pg_on;
        ctl_d.fault = (ctl_d.st == ST_FAULT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, cnt: '0, gh_seen: 1'b0, ho_run: 1'b0,
                       ho_done: 1'b0, gate: 1'b0, pg_n: 1'b1, fault: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign gate_en   = ctl_q.gate;
    assign pg_n      = ctl_q.pg_n;
    assign fault_req = ctl_q.fault;
endmodule

// File: rtl/hs_seq_chk.sv
module hs_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic gate_en,
    input logic pg_n,
    input logic fault_req,
    input logic ok_s,
    input logic men_s
);
    AST_PG_NEEDS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !pg_n |-> gate_en); // R5

    AST_PG_NOT_ON_GATE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_en) |-> pg_n); // R5

    AST_GATE_RISE_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_en) |-> $past(ok_s)); // R2

    AST_FAULT_OUTPUTS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        fault_req |-> (!gate_en && pg_n)); // R8

    AST_FAULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_req && men_s) |=> fault_req); // R12

    AST_ENABLE_LOSS_DROPS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en && !ok_s) |=> !gate_en); // R10
endmodule

bind hs_seq_ctrl hs_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .gate_en   (gate_en),
    .pg_n      (pg_n),
    .fault_req (fault_req),
    .ok_s      (all_ok_s),
    .men_s     (men_s)
);

// File: tb/hs_seq_ctrl_tb_top.sv
module hs_seq_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic seat_a_n = 1'b1, seat_b_n = 1'b1, master_en = 1'b0, supply_ok = 1'b0;
    logic gate_high = 1'b0, drain_low = 1'b0, pg_en = 1'b1, fshut_n = 1'b1;
    logic prot_fault = 1'b0, fshut_is_pg_en = 1'b0;
    logic [1:0] qual_sel = 2'b01;   // 10 units -> 20 cycles
    logic [2:0] pgd_sel  = 3'b010;  // 5 units  -> 10 cycles
    logic gate_en, pg_n, fault_req;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int    at;
        logic  g;
        logic  p;
        logic  f;
        string tag;
    } exp_t;
    exp_t sb_q[$];

    always #5 clk = ~clk;

    hs_seq_ctrl #(.CLK_PER_UNIT(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .seat_a_n(seat_a_n), .seat_b_n(seat_b_n),
        .master_en(master_en), .supply_ok(supply_ok), .gate_high(gate_high),
        .drain_low(drain_low), .pg_en(pg_en), .fshut_n(fshut_n),
        .prot_fault(prot_fault), .qual_sel(qual_sel), .pgd_sel(pgd_sel),
        .fshut_is_pg_en(fshut_is_pg_en), .gate_en(gate_en), .pg_n(pg_n),
        .fault_req(fault_req)
    );

    // driver side: expected outputs after the d-th rising edge from now
    task automatic expect_at(input int d, input logic g, input logic p,
                             input logic f, input string tag);
        exp_t e;
        e.at = cyc + d; e.g = g; e.p = p; e.f = f; e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: compare due items shortly after each rising edge
    always @(posedge clk) begin
        #1;
        cyc++;
        for (int i = sb_q.size() - 1; i >= 0; i--) begin
            if (sb_q[i].at == cyc) begin
                checks++;
                if (gate_en !== sb_q[i].g || pg_n !== sb_q[i].p || fault_req !== sb_q[i].f) begin
                    errors++;
                    $display("FAIL %s @%0d: got gate=%0b pg_n=%0b fault=%0b exp gate=%0b pg_n=%0b fault=%0b",
                             sb_q[i].tag, cyc, gate_en, pg_n, fault_req,
                             sb_q[i].g, sb_q[i].p, sb_q[i].f);
                end
                sb_q.delete(i);
            end
        end
    end

    initial begin
        step(3);
        expect_at(1, 1'b0, 1'b1, 1'b0, "R1 in reset");
        step(2);
        rst_n = 1'b1;
        expect_at(2, 1'b0, 1'b1, 1'b0, "R1 after reset");
        step(4);

        // R2 R3: qualification with code 01 (20 cycles)
        seat_a_n = 1'b0; seat_b_n = 1'b0; master_en = 1'b1; supply_ok = 1'b1;
        expect_at(22, 1'b0, 1'b1, 1'b0, "R2 before interval");
        expect_at(23, 1'b1, 1'b1, 1'b0, "R2 R3 gate on");
        step(26);

        // R5: drain low alone is not enough
        drain_low = 1'b1;
        expect_at(15, 1'b1, 1'b1, 1'b0, "R5 no gate-high seen");
        step(16);
        // R5 R6: one-cycle gate_high pulse is latched, then 10-cycle delay
        gate_high = 1'b1;
        expect_at(12, 1'b1, 1'b1, 1'b0, "R6 before pg delay");
        expect_at(13, 1'b1, 1'b0, 1'b0, "R5 R6 pg on");
        step(1);
        gate_high = 1'b0;
        step(15);

        // R7: power-good enable
        pg_en = 1'b0;
        expect_at(2, 1'b1, 1'b0, 1'b0, "R7 not yet released");
        expect_at(3, 1'b1, 1'b1, 1'b0, "R7 released");
        step(5);
        pg_en = 1'b1;
        expect_at(3, 1'b1, 1'b0, 1'b0, "R7 driven");
        step(5);

        // R13: drain sensor active while on
        drain_low = 1'b0;
        expect_at(3, 1'b1, 1'b1, 1'b0, "R13 released");
        expect_at(6, 1'b1, 1'b1, 1'b0, "R13 no fault");
        step(7);
        drain_low = 1'b1;
        expect_at(3, 1'b1, 1'b0, 1'b0, "R13 driven again");
        step(5);

        // R10: seat loss
        seat_b_n = 1'b1;
        expect_at(2, 1'b1, 1'b0, 1'b0, "R10 before loss");
        expect_at(3, 1'b0, 1'b1, 1'b0, "R10 seat loss");
        step(5);

        // R4: abort mid qualification and restart
        seat_b_n = 1'b0;
        step(10);
        seat_a_n = 1'b1;
        step(3);
        seat_a_n = 1'b0;
        expect_at(22, 1'b0, 1'b1, 1'b0, "R4 count restarted");
        expect_at(23, 1'b1, 1'b1, 1'b0, "R4 gate after full interval");
        step(24);

        // R8: forced shutdown low during and after holdoff
        fshut_n = 1'b0; gate_high = 1'b1;
        expect_at(13, 1'b1, 1'b0, 1'b0, "R8 pg on despite fshut");
        expect_at(23, 1'b1, 1'b0, 1'b0, "R8 last holdoff cycle");
        expect_at(24, 1'b0, 1'b1, 1'b1, "R8 fault after holdoff");
        step(26);

        // R12: fault held, cleared by master enable low
        fshut_n = 1'b1;
        expect_at(6, 1'b0, 1'b1, 1'b1, "R12 fault held");
        step(8);
        master_en = 1'b0;
        expect_at(2, 1'b0, 1'b1, 1'b1, "R12 before clear");
        expect_at(3, 1'b0, 1'b1, 1'b0, "R12 cleared");
        step(5);

        // requalify, then R11 protection fault
        master_en = 1'b1;
        expect_at(23, 1'b1, 1'b1, 1'b0, "R2 requalified");
        expect_at(34, 1'b1, 1'b0, 1'b0, "R5 pg after ramp");
        step(36);
        prot_fault = 1'b1;
        expect_at(3, 1'b0, 1'b1, 1'b1, "R11 protection fault");
        step(5);
        prot_fault = 1'b0; master_en = 1'b0;
        step(6);

        // R9: forced shutdown as second power-good enable
        fshut_is_pg_en = 1'b1; master_en = 1'b1;
        expect_at(34, 1'b1, 1'b0, 1'b0, "R9 pg on");
        step(36);
        fshut_n = 1'b0;
        expect_at(3, 1'b1, 1'b1, 1'b0, "R9 pg released");
        expect_at(40, 1'b1, 1'b1, 1'b0, "R9 no fault");
        step(41);
        fshut_n = 1'b1;
        expect_at(3, 1'b1, 1'b0, 1'b0, "R9 pg driven");
        step(5);

        // R3 R6: default codes (3200 and 200 cycles)
        master_en = 1'b0; fshut_is_pg_en = 1'b0;
        qual_sel = 2'b00; pgd_sel = 3'b000;
        step(6);
        master_en = 1'b1;
        expect_at(3202, 1'b0, 1'b1, 1'b0, "R3 default before");
        expect_at(3203, 1'b1, 1'b1, 1'b0, "R3 default gate");
        expect_at(3403, 1'b1, 1'b1, 1'b0, "R6 default before");
        expect_at(3404, 1'b1, 1'b0, 1'b0, "R6 default pg");
        step(3410);

        if (sb_q.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL scoreboard: %0d items left, expected 0", sb_q.size());
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule